// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits next to an 8-bit execution core with a 16-bit program counter. At every instruction boundary it decides whether an interrupt is taken. The core signals the boundary with a one-cycle strobe. The block owns the two interrupt-enable flip-flops and the interrupt-mode register, and the core updates them through simple write ports: enable/disable, return-from-NMI restore, and mode set.

When a maskable request is taken, the block tells the core which opcode to execute next:
- In mode 0 the data-bus byte itself is the opcode.
- In mode 1 it is the restart opcode 0xFF.
- In mode 2 it is the call opcode 0xCD, with a vector address built from the I register (high byte) and the bus byte (low byte).

When a non-maskable request is taken, the block streams the current PC out as two push bytes and asks the core to jump to the fixed NMI entry point. Every accepted event also reports its extra cycle cost.

All outputs are registered. A decision made on the strobe edge is visible from the following cycle.

Top module: `intr_accept_seq`

## Requirements
- R1: Synchronous reset leaves both enable flags at 0, the mode at 0, and no action, acknowledge, jump or push asserted.
- R2: A maskable request while the first enable flag is 0 is ignored: no action is reported and both flags keep their values.
- R3: Taking a maskable request clears both enable flags, pulses `irq_ack_o` for one cycle and reports a cost of 6 cycles.
- R4: In mode 0 the injected opcode equals the data-bus byte.
- R5: In mode 1 the injected opcode is 0xFF.
- R6: In mode 2 the injected opcode is 0xCD and `vector_o` equals {I register, data-bus byte}.
- R7: The maskable request is evaluated first. A pending NMI is taken only at a strobe where no maskable request is taken, and it stays pending across a strobe that took the maskable one.
- R8: Taking an NMI clears the first enable flag, leaves the second unchanged, raises `jump_en_o` with `jump_addr_o` = 0x0066 and reports a cost of 5 cycles.
- R9: On NMI acceptance, the PC high byte appears on `push_byte_o` in the cycle of `jump_en_o`, and the low byte appears in the next cycle, with `push_en_o` high in both cycles.
- R10: The NMI input is edge-sensitive. A rising edge between strobes is remembered until it is taken, and a level held high after acceptance does not cause a second acceptance.
- R11: The mode-set code written through `im_sel_i` maps as follows: 2'b00 and 2'b01 give mode 0, 2'b10 gives mode 1, 2'b11 gives mode 2.
- R12: Without the boundary strobe no interrupt is taken, whatever the request inputs are.
- R13: A flag write sets both flags to `ie_val_i`. A restore pulse copies the second flag into the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Instruction-boundary strobe |
| pc_i | input | 16 | Current program counter |
| i_reg_i | input | 8 | I register (vector high byte) |
| irq_i | input | 1 | Maskable request, level |
| irq_data_i | input | 8 | Data-bus byte supplied with the request |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| ie_we_i | input | 1 | Write both enable flags |
| ie_val_i | input | 1 | Value for the flag write |
| retn_i | input | 1 | Copy second flag into first |
| im_we_i | input | 1 | Write interrupt mode |
| im_sel_i | input | 2 | Mode-set code |
| iff1_o | output | 1 | First enable flag |
| iff2_o | output | 1 | Second enable flag |
| imode_o | output | 2 | Current mode (0, 1, 2) |
| act_o | output | 1 | An interrupt was taken (one cycle) |
| irq_ack_o | output | 1 | The taken interrupt was maskable |
| inject_en_o | output | 1 | Execute `inject_op_o` next |
| inject_op_o | output | 8 | Opcode to inject |
| vector_o | output | 16 | Mode-2 vector address |
| jump_en_o | output | 1 | Push-PC-and-jump request |
| jump_addr_o | output | 16 | Jump target |
| push_en_o | output | 1 | `push_byte_o` is valid |
| push_byte_o | output | 8 | Byte to push, high first |
| cost_o | output | 4 | Extra cycle cost of the taken interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, so a 16-bit PC pushed as exactly two bytes, the 0x0066 entry point, and costs of 6 and 5 in a 4-bit field. With these values every mode, the two-byte push order, and the exact vector composition can be compared against literal expected values. The NMI tests also cover an edge arriving between strobes, a level held through acceptance, and an NMI deferred by a simultaneous maskable request.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  localparam logic [1:0] MODE_0 = 2'd0;
  localparam logic [1:0] MODE_1 = 2'd1;
  localparam logic [1:0] MODE_2 = 2'd2;

  // Mode-set code from the core. Both low codes select mode 0.
  function automatic logic [1:0] decode_mode(input logic [1:0] sel);
    logic [1:0] m;
    case (sel)
      2'b10:   m = MODE_1;
      2'b11:   m = MODE_2;
      default: m = MODE_0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/intr_edge_latch.sv
module intr_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic clear_i,
  output logic pend_o
);
  logic prev_q;
  logic rise;

  assign rise = level_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (rise)
        pend_o <= 1'b1;
      else if (clear_i)
        pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_state_regs.sv
module intr_state_regs
  import intr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ie_we_i,
  input  logic       ie_val_i,
  input  logic       retn_i,
  input  logic       im_we_i,
  input  logic [1:0] im_sel_i,
  input  logic       take_irq_i,
  input  logic       take_nmi_i,
  output logic       iff1_o,
  output logic       iff2_o,
  output logic [1:0] imode_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      iff1_o  <= 1'b0;
      iff2_o  <= 1'b0;
      imode_o <= MODE_0;
    end else begin
      if (take_irq_i) begin
        iff1_o <= 1'b0;
        iff2_o <= 1'b0;
      end else if (take_nmi_i) begin
        iff1_o <= 1'b0;
      end else if (ie_we_i) begin
        iff1_o <= ie_val_i;
        iff2_o <= ie_val_i;
      end else if (retn_i) begin
        iff1_o <= iff2_o;
      end
      if (im_we_i)
        imode_o <= decode_mode(im_sel_i);
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] RST_OP  = 8'hFF,
  parameter logic [BYTE_W-1:0] CALL_OP = 8'hCD,
  localparam int VEC_W = 2 * BYTE_W
) (
  input  logic              step_i,
  input  logic              irq_i,
  input  logic              iff1_i,
  input  logic              nmi_pend_i,
  input  logic [1:0]        imode_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [BYTE_W-1:0] i_reg_i,
  output logic              take_irq_o,
  output logic              take_nmi_o,
  output logic [BYTE_W-1:0] op_o,
  output logic [VEC_W-1:0]  vec_o
);
  // Maskable request has first claim on the boundary.
  assign take_irq_o = step_i & irq_i & iff1_i;
  assign take_nmi_o = step_i & nmi_pend_i & ~take_irq_o;

  always_comb begin
    vec_o = '0;
    case (imode_i)
      MODE_1:  op_o = RST_OP;
      MODE_2: begin
        op_o  = CALL_OP;
        vec_o = {i_reg_i, data_i};
      end
      default: op_o = data_i;
    endcase
  end
endmodule

// File: rtl/intr_push_seq.sv
module intr_push_seq #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16,
  localparam int NB    = ADDR_W / BYTE_W,
  localparam int CNT_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              push_en_o,
  output logic [BYTE_W-1:0] push_byte_o
);
  logic [ADDR_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      left_q      <= '0;
      push_en_o   <= 1'b0;
      push_byte_o <= '0;
    end else if (start_i) begin
      push_en_o   <= 1'b1;
      push_byte_o <= pc_i[ADDR_W-1 -: BYTE_W];
      sh_q        <= pc_i << BYTE_W;
      left_q      <= CNT_W'(NB - 1);
    end else if (left_q != '0) begin
      push_en_o   <= 1'b1;
      push_byte_o <= sh_q[ADDR_W-1 -: BYTE_W];
      sh_q        <= sh_q << BYTE_W;
      left_q      <= left_q - 1'b1;
    end else begin
      push_en_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_accept_seq.sv
module intr_accept_seq
  import intr_seq_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int COST_W   = 4,
  parameter int IRQ_COST = 6,
  parameter int NMI_COST = 5,
  parameter logic [2*BYTE_W-1:0] NMI_VEC = 16'h0066,
  parameter logic [BYTE_W-1:0]   RST_OP  = 8'hFF,
  parameter logic [BYTE_W-1:0]   CALL_OP = 8'hCD,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] i_reg_i,
  input  logic              irq_i,
  input  logic [BYTE_W-1:0] irq_data_i,
  input  logic              nmi_i,
  input  logic              ie_we_i,
  input  logic              ie_val_i,
  input  logic              retn_i,
  input  logic              im_we_i,
  input  logic [1:0]        im_sel_i,
  output logic              iff1_o,
  output logic              iff2_o,
  output logic [1:0]        imode_o,
  output logic              act_o,
  output logic              irq_ack_o,
  output logic              inject_en_o,
  output logic [BYTE_W-1:0] inject_op_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              jump_en_o,
  output logic [ADDR_W-1:0] jump_addr_o,
  output logic              push_en_o,
  output logic [BYTE_W-1:0] push_byte_o,
  output logic [COST_W-1:0] cost_o
);
  logic              nmi_pend;
  logic              take_irq;
  logic              take_nmi;
  logic [BYTE_W-1:0] arb_op;
  logic [ADDR_W-1:0] arb_vec;

  intr_edge_latch u_nmi (
    .clk     (clk),
    .rst     (rst),
    .level_i (nmi_i),
    .clear_i (take_nmi),
    .pend_o  (nmi_pend)
  );

  intr_state_regs u_state (
    .clk        (clk),
    .rst        (rst),
    .ie_we_i    (ie_we_i),
    .ie_val_i   (ie_val_i),
    .retn_i     (retn_i),
    .im_we_i    (im_we_i),
    .im_sel_i   (im_sel_i),
    .take_irq_i (take_irq),
    .take_nmi_i (take_nmi),
    .iff1_o     (iff1_o),
    .iff2_o     (iff2_o),
    .imode_o    (imode_o)
  );

  intr_arbiter #(
    .BYTE_W  (BYTE_W),
    .RST_OP  (RST_OP),
    .CALL_OP (CALL_OP)
  ) u_arb (
    .step_i     (step_i),
    .irq_i      (irq_i),
    .iff1_i     (iff1_o),
    .nmi_pend_i (nmi_pend),
    .imode_i    (imode_o),
    .data_i     (irq_data_i),
    .i_reg_i    (i_reg_i),
    .take_irq_o (take_irq),
    .take_nmi_o (take_nmi),
    .op_o       (arb_op),
    .vec_o      (arb_vec)
  );

  intr_push_seq #(
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W)
  ) u_push (
    .clk         (clk),
    .rst         (rst),
    .start_i     (take_nmi),
    .pc_i        (pc_i),
    .push_en_o   (push_en_o),
    .push_byte_o (push_byte_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o       <= 1'b0;
      irq_ack_o   <= 1'b0;
      inject_en_o <= 1'b0;
      inject_op_o <= '0;
      vector_o    <= '0;
      jump_en_o   <= 1'b0;
      jump_addr_o <= '0;
      cost_o      <= '0;
    end else begin
      act_o       <= take_irq | take_nmi;
      irq_ack_o   <= take_irq;
      inject_en_o <= take_irq;
      jump_en_o   <= take_nmi;
      if (take_irq) begin
        inject_op_o <= arb_op;
        vector_o    <= arb_vec;
        cost_o      <= COST_W'(IRQ_COST);
      end else if (take_nmi) begin
        jump_addr_o <= NMI_VEC;
        cost_o      <= COST_W'(NMI_COST);
      end
    end
  end
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk #(
  parameter int BYTE_W   = 8,
  parameter int COST_W   = 4,
  parameter int IRQ_COST = 6,
  parameter int NMI_COST = 5,
  parameter logic [2*BYTE_W-1:0] NMI_VEC = 16'h0066,
  parameter logic [BYTE_W-1:0]   CALL_OP = 8'hCD,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              step_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              iff1_o,
  input logic              iff2_o,
  input logic [1:0]        imode_o,
  input logic              act_o,
  input logic              irq_ack_o,
  input logic [BYTE_W-1:0] inject_op_o,
  input logic              jump_en_o,
  input logic [ADDR_W-1:0] jump_addr_o,
  input logic              push_en_o,
  input logic [BYTE_W-1:0] push_byte_o,
  input logic [COST_W-1:0] cost_o
);
  assert_masked_R2: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> $past(iff1_o));

  assert_irq_clears_R3: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> (!iff1_o && !iff2_o && cost_o == COST_W'(IRQ_COST)));

  assert_mode2_call_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_o && $past(imode_o) == 2'd2) |-> inject_op_o == CALL_OP);

  assert_one_kind_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_ack_o, jump_en_o}));

  assert_nmi_flags_R8: assert property (@(posedge clk) disable iff (rst)
    jump_en_o |-> (!iff1_o && iff2_o == $past(iff2_o) &&
                   jump_addr_o == NMI_VEC && cost_o == COST_W'(NMI_COST)));

  assert_push_high_R9: assert property (@(posedge clk) disable iff (rst)
    jump_en_o |-> (push_en_o && push_byte_o == $past(pc_i[ADDR_W-1 -: BYTE_W])));

  assert_needs_step_R12: assert property (@(posedge clk) disable iff (rst)
    act_o |-> $past(step_i));
endmodule

bind intr_accept_seq intr_accept_chk #(
  .BYTE_W   (BYTE_W),
  .COST_W   (COST_W),
  .IRQ_COST (IRQ_COST),
  .NMI_COST (NMI_COST),
  .NMI_VEC  (NMI_VEC),
  .CALL_OP  (CALL_OP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .step_i      (step_i),
  .pc_i        (pc_i),
  .iff1_o      (iff1_o),
  .iff2_o      (iff2_o),
  .imode_o     (imode_o),
  .act_o       (act_o),
  .irq_ack_o   (irq_ack_o),
  .inject_op_o (inject_op_o),
  .jump_en_o   (jump_en_o),
  .jump_addr_o (jump_addr_o),
  .push_en_o   (push_en_o),
  .push_byte_o (push_byte_o),
  .cost_o      (cost_o)
);

// File: tb/tb_intr_accept_seq.sv
module tb_intr_accept_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  i_reg_i = '0;
  logic        irq_i = 1'b0;
  logic [7:0]  irq_data_i = '0;
  logic        nmi_i = 1'b0;
  logic        ie_we_i = 1'b0;
  logic        ie_val_i = 1'b0;
  logic        retn_i = 1'b0;
  logic        im_we_i = 1'b0;
  logic [1:0]  im_sel_i = '0;
  logic        iff1_o, iff2_o, act_o, irq_ack_o, inject_en_o, jump_en_o, push_en_o;
  logic [1:0]  imode_o;
  logic [7:0]  inject_op_o, push_byte_o;
  logic [15:0] vector_o, jump_addr_o;
  logic [3:0]  cost_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_accept_seq dut (
    .clk(clk), .rst(rst), .step_i(step_i), .pc_i(pc_i), .i_reg_i(i_reg_i),
    .irq_i(irq_i), .irq_data_i(irq_data_i), .nmi_i(nmi_i),
    .ie_we_i(ie_we_i), .ie_val_i(ie_val_i), .retn_i(retn_i),
    .im_we_i(im_we_i), .im_sel_i(im_sel_i),
    .iff1_o(iff1_o), .iff2_o(iff2_o), .imode_o(imode_o),
    .act_o(act_o), .irq_ack_o(irq_ack_o), .inject_en_o(inject_en_o),
    .inject_op_o(inject_op_o), .vector_o(vector_o), .jump_en_o(jump_en_o),
    .jump_addr_o(jump_addr_o), .push_en_o(push_en_o), .push_byte_o(push_byte_o),
    .cost_o(cost_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One boundary strobe; returns sampled after the deciding edge.
  task automatic step_once();
    @(negedge clk); step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
  endtask

  task automatic set_flags(input bit v);
    @(negedge clk); ie_we_i = 1'b1; ie_val_i = v;
    @(negedge clk); ie_we_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] sel);
    @(negedge clk); im_we_i = 1'b1; im_sel_i = sel;
    @(negedge clk); im_we_i = 1'b0;
  endtask

  task automatic nmi_pulse();
    @(negedge clk); nmi_i = 1'b1;
    @(negedge clk); nmi_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 iff1", iff1_o, 0);
    check("R1 iff2", iff2_o, 0);
    check("R1 mode", imode_o, 0);
    check("R1 act", act_o, 0);
    check("R1 push", push_en_o, 0);
  endtask

  task automatic t_mode_codes();
    set_mode(2'b01); check("R11 code01", imode_o, 0);
    set_mode(2'b10); check("R11 code10", imode_o, 1);
    set_mode(2'b11); check("R11 code11", imode_o, 2);
    set_mode(2'b00); check("R11 code00", imode_o, 0);
  endtask

  task automatic t_masked();
    set_flags(1'b0);
    irq_i = 1'b1; irq_data_i = 8'h55;
    step_once();
    check("R2 act", act_o, 0);
    check("R2 iff2", iff2_o, 0);
    irq_i = 1'b0;
  endtask

  task automatic t_no_step();
    set_flags(1'b1);
    irq_i = 1'b1;
    nmi_pulse();
    repeat (4) begin
      @(negedge clk);
      check("R12 act", act_o, 0);
    end
    check("R12 iff1", iff1_o, 1);
    irq_i = 1'b0;
    step_once();   // drains the remembered NMI
    check("R10 remembered", jump_en_o, 1);
    @(negedge clk);
    set_flags(1'b0);
  endtask

  task automatic t_irq(input logic [1:0] sel, input logic [7:0] data,
                       input logic [7:0] ireg, input int exp_op, input int exp_vec,
                       input string req);
    set_mode(sel);
    set_flags(1'b1);
    irq_i = 1'b1; irq_data_i = data; i_reg_i = ireg;
    step_once();
    irq_i = 1'b0;
    check({req, " op"}, inject_op_o, exp_op);
    check({req, " inj"}, inject_en_o, 1);
    check({req, " vec"}, vector_o, exp_vec);
    check("R3 ack", irq_ack_o, 1);
    check("R3 cost", cost_o, 6);
    check("R3 iff1", iff1_o, 0);
    check("R3 iff2", iff2_o, 0);
    @(negedge clk);
    check("R3 ack one cycle", irq_ack_o, 0);
  endtask

  task automatic t_nmi();
    set_flags(1'b1);
    pc_i = 16'hBEEF;
    nmi_pulse();
    step_once();
    check("R8 jump", jump_en_o, 1);
    check("R8 addr", jump_addr_o, 16'h0066);
    check("R8 cost", cost_o, 5);
    check("R8 iff1", iff1_o, 0);
    check("R8 iff2", iff2_o, 1);
    check("R9 push hi en", push_en_o, 1);
    check("R9 push hi", push_byte_o, 8'hBE);
    pc_i = 16'h0000;
    @(negedge clk);
    check("R9 push lo en", push_en_o, 1);
    check("R9 push lo", push_byte_o, 8'hEF);
    @(negedge clk);
    check("R9 push done", push_en_o, 0);
    @(negedge clk); retn_i = 1'b1;
    @(negedge clk); retn_i = 1'b0;
    check("R13 restore", iff1_o, 1);
    set_flags(1'b0);
    check("R13 clear iff2", iff2_o, 0);
  endtask

  task automatic t_level_held();
    @(negedge clk); nmi_i = 1'b1;
    step_once();
    check("R10 first", jump_en_o, 1);
    repeat (2) @(negedge clk);
    step_once();
    check("R10 held no retrigger", act_o, 0);
    nmi_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_priority();
    set_mode(2'b10);
    set_flags(1'b1);
    irq_i = 1'b1; irq_data_i = 8'h00;
    nmi_pulse();
    step_once();
    irq_i = 1'b0;
    check("R7 irq first", irq_ack_o, 1);
    check("R7 no jump", jump_en_o, 0);
    check("R5 rst op", inject_op_o, 8'hFF);
    step_once();
    check("R7 nmi after", jump_en_o, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode_codes();
    t_masked();
    t_no_step();
    t_irq(2'b00, 8'hC7, 8'h00, 8'hC7, 0, "R4 mode0");
    t_irq(2'b10, 8'h12, 8'h00, 8'hFF, 0, "R5 mode1");
    t_irq(2'b11, 8'h10, 8'h3A, 8'hCD, 16'h3A10, "R6 mode2");
    t_nmi();
    t_level_held();
    t_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule